// File: doc/BRIEF.md
# Barrel Shifter Shift-Control Selector

This block supplies the shift amount (5 bits) and the shift type (2 bits) that steer a 32-bit barrel shifter. On every cycle a 3-bit command from the instruction sequencer picks one of several sources for these controls. The sources are an immediate shift field taken from the instruction, a byte captured earlier from a register read port, a fixed left shift by two for branch offsets, a doubled rotate count for rotated immediates, and a byte-lane rotate derived from the two low address bits. One command is a neutral selection that leaves the shifter carry untouched.

A shift whose amount is held in a register takes two cycles. In the first cycle the low byte of the register read bus is captured into an 8-bit holding register. In the second cycle that byte becomes the shift amount. A captured value of 32 or more cannot be expressed in five bits. The block then drives an amount of zero and raises a separate out-of-range flag, which the shifter's carry and sign logic uses. The shift outputs are combinational from the command, the instruction field, the address bits and the holding register, so they are valid in the same cycle the command is presented.

Top module: `shift_ctl_sel`

## Requirements
- R1: After reset the holding register is zero. A command 000 issued before any load yields amount 0 with out-of-range low.
- R2: Command 111 captures `rbus_i[7:0]` into the holding register at the rising clock edge. During the command 111 cycle the outputs are amount 0 and type 00.
- R3: Every command other than 111 leaves the holding register unchanged, whatever value `rbus_i` carries.
- R4: Command 000 drives the held value as the amount and `ifield_i[1:0]` (instruction bits 6..5) as the type, when the held value is below 32.
- R5: Command 000 with a held value of 32 or more drives amount 0 and sets `oor_o`. `oor_o` is 0 under every other command.
- R6: Command 001 drives amount `ifield_i[6:2]` (instruction bits 11..7) and type `ifield_i[1:0]`.
- R7: Command 010 is a no-op and drives amount 0, type 00.
- R8: Command 011 drives amount 2, type 00 (logical left).
- R9: Command 100 drives amount 2 × `ifield_i[6:3]` (instruction bits 11..8). The type is 11 (rotate right) when that amount is non-zero and 00 when it is zero.
- R10: Command 101 drives amount 8 × `alo_i`. The type is 11 when `alo_i` is non-zero and 00 when it is zero.
- R11: Command 110 drives amount 0, type 00.

Shift type encoding: 00 logical left, 01 logical right, 10 arithmetic right, 11 rotate right.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cmd_i | input | 3 | Shift-control command from the sequencer |
| ifield_i | input | 7 | Instruction bits 11..5 (bit 6 of this port = instruction bit 11) |
| rbus_i | input | 8 | Low byte of the register read bus |
| alo_i | input | 2 | Address bits 1..0 |
| amt_o | output | 5 | Shift amount to the shifter drivers |
| typ_o | output | 2 | Shift type to the shifter drivers |
| oor_o | output | 1 | Held amount was 32 or more |

## Verification
The bench targets the boundary between held values 31 and 32, and also 255. A design that compares against the wrong limit either passes a truncated amount such as 0 for 32 without flagging it, or flags a legal 31. It drives changing read-bus values under every non-load command and then reads the held byte back through command 000, which exposes a holding register that loads too often. The rotated-immediate and byte-lane commands are exercised with zero and non-zero counts. A design that got this wrong would emit rotate-right #0, which the shifter treats as a different operation, or would double the count by the wrong factor. The spare command 110 and the load cycle itself are checked for neutral outputs, which catches a decoder that lets a stale source through.

// File: rtl/shift_ctl_pkg.sv
package shift_ctl_pkg;

    localparam int SC_AMT_W  = 5;
    localparam int SC_TYP_W  = 2;
    localparam int SC_CMD_W  = 3;
    localparam int SC_NCMD   = 1 << SC_CMD_W;
    localparam int SC_HOLD_W = 8;
    localparam int SC_FLD_W  = 7;
    localparam int SC_ALO_W  = 2;

    typedef enum logic [SC_CMD_W-1:0] {
        CMD_REG   = 3'b000,
        CMD_FIELD = 3'b001,
        CMD_NOP   = 3'b010,
        CMD_BR    = 3'b011,
        CMD_IMM   = 3'b100,
        CMD_BYTE  = 3'b101,
        CMD_SPARE = 3'b110,
        CMD_LOAD  = 3'b111
    } sc_cmd_e;

    typedef enum logic [SC_TYP_W-1:0] {
        TY_LSL = 2'b00,
        TY_LSR = 2'b01,
        TY_ASR = 2'b10,
        TY_ROR = 2'b11
    } sc_typ_e;

    typedef struct packed {
        logic [SC_AMT_W-1:0] amt;
        logic [SC_TYP_W-1:0] typ;
        logic                oor;
    } sc_res_t;

endpackage

// File: rtl/sc_hold_reg.sv
module sc_hold_reg
    import shift_ctl_pkg::*;
#(
    parameter int HOLD_W = SC_HOLD_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [SC_CMD_W-1:0] cmd_i,
    input  logic [HOLD_W-1:0] rbus_i,
    output logic [HOLD_W-1:0] hold_o
);

    typedef struct packed {
        logic [HOLD_W-1:0] val;
    } hold_st_t;

    hold_st_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (cmd_i == CMD_LOAD) begin
            st_d.val = rbus_i;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign hold_o = st_q.val;

    // R3
    hold_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_i != CMD_LOAD) |=> $stable(hold_o));

    // R2
    hold_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_i == CMD_LOAD) |=> (hold_o == $past(rbus_i)));

endmodule

// File: rtl/sc_source_gen.sv
module sc_source_gen
    import shift_ctl_pkg::*;
#(
    parameter int AMT_W  = SC_AMT_W,
    parameter int HOLD_W = SC_HOLD_W,
    parameter int FLD_W  = SC_FLD_W,
    parameter int ALO_W  = SC_ALO_W,
    parameter int NCMD   = SC_NCMD
) (
    input  logic [HOLD_W-1:0]    hold_i,
    input  logic [FLD_W-1:0]     ifield_i,
    input  logic [ALO_W-1:0]     alo_i,
    output sc_res_t [NCMD-1:0]   src_o
);

    localparam int TYP_W   = SC_TYP_W;
    localparam int ROT_W   = AMT_W - 1;
    localparam int LANE_SH = 3;
    localparam int BR_SH   = 2;

    logic             big_held;
    logic [AMT_W-1:0] held_amt;
    logic [AMT_W-1:0] imm_amt;
    logic [AMT_W-1:0] lane_amt;

    always_comb begin
        big_held = |hold_i[HOLD_W-1:AMT_W];
        held_amt = big_held ? '0 : hold_i[AMT_W-1:0];
        imm_amt  = {ifield_i[FLD_W-1 -: ROT_W], 1'b0};
        lane_amt = AMT_W'({alo_i, LANE_SH'(0)});
    end

    for (genvar g = 0; g < NCMD; g++) begin : g_src
        sc_res_t res;
        always_comb begin
            res = '0;
            case (sc_cmd_e'(g))
                CMD_REG: begin
                    res.amt = held_amt;
                    res.typ = ifield_i[TYP_W-1:0];
                    res.oor = big_held;
                end
                CMD_FIELD: begin
                    res.amt = ifield_i[FLD_W-1 -: AMT_W];
                    res.typ = ifield_i[TYP_W-1:0];
                end
                CMD_BR: begin
                    res.amt = AMT_W'(BR_SH);
                    res.typ = TY_LSL;
                end
                CMD_IMM: begin
                    res.amt = imm_amt;
                    res.typ = (imm_amt != '0) ? TY_ROR : TY_LSL;
                end
                CMD_BYTE: begin
                    res.amt = lane_amt;
                    res.typ = (alo_i != '0) ? TY_ROR : TY_LSL;
                end
                default: begin
                    res.amt = '0;
                    res.typ = TY_LSL;
                end
            endcase
        end
        assign src_o[g] = res;
    end

endmodule

// File: rtl/sc_out_mux.sv
module sc_out_mux
    import shift_ctl_pkg::*;
#(
    parameter int NCMD = SC_NCMD
) (
    input  logic [SC_CMD_W-1:0]  cmd_i,
    input  sc_res_t [NCMD-1:0]   src_i,
    output sc_res_t              sel_o
);

    always_comb begin
        sel_o = '0;
        for (int k = 0; k < NCMD; k++) begin
            if (cmd_i == SC_CMD_W'(k)) begin
                sel_o = src_i[k];
            end
        end
    end

endmodule

// File: rtl/shift_ctl_sel.sv
module shift_ctl_sel
    import shift_ctl_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic [2:0] cmd_i,
    input  logic [6:0] ifield_i,
    input  logic [7:0] rbus_i,
    input  logic [1:0] alo_i,
    output logic [4:0] amt_o,
    output logic [1:0] typ_o,
    output logic       oor_o
);

    logic [SC_HOLD_W-1:0]  hold_q;
    sc_res_t [SC_NCMD-1:0] src;
    sc_res_t               sel;

    sc_hold_reg #(.HOLD_W(SC_HOLD_W)) i_hold (
        .clk    (clk),
        .rst_n  (rst_n),
        .cmd_i  (cmd_i),
        .rbus_i (rbus_i),
        .hold_o (hold_q)
    );

    sc_source_gen #(
        .AMT_W  (SC_AMT_W),
        .HOLD_W (SC_HOLD_W),
        .FLD_W  (SC_FLD_W),
        .ALO_W  (SC_ALO_W),
        .NCMD   (SC_NCMD)
    ) i_src (
        .hold_i   (hold_q),
        .ifield_i (ifield_i),
        .alo_i    (alo_i),
        .src_o    (src)
    );

    sc_out_mux #(.NCMD(SC_NCMD)) i_mux (
        .cmd_i (cmd_i),
        .src_i (src),
        .sel_o (sel)
    );

    assign amt_o = sel.amt;
    assign typ_o = sel.typ;
    assign oor_o = sel.oor;

    // R5
    oor_cmd_chk: assert property (@(posedge clk) disable iff (!rst_n)
        oor_o |-> (cmd_i == CMD_REG && amt_o == '0));

    // R8
    br_shift_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_i == CMD_BR) |-> (amt_o == 5'd2 && typ_o == TY_LSL));

    // R9
    imm_rot_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_i == CMD_IMM) |-> (amt_o[0] == 1'b0 && (typ_o == TY_ROR) == (ifield_i[6:3] != '0)));

    // R10
    lane_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_i == CMD_BYTE) |-> (amt_o[2:0] == '0 && (typ_o == TY_ROR) == (alo_i != '0)));

    // R7
    nop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_i == CMD_NOP || cmd_i == CMD_SPARE || cmd_i == CMD_LOAD) |-> (amt_o == '0 && typ_o == TY_LSL));

endmodule

// File: tb/test_shift_ctl_sel.sv
module test_shift_ctl_sel;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [2:0] cmd_i = 3'b010;
    logic [6:0] ifield_i = '0;
    logic [7:0] rbus_i = '0;
    logic [1:0] alo_i = '0;
    logic [4:0] amt_o;
    logic [1:0] typ_o;
    logic       oor_o;

    int n_chk = 0;
    int n_bad = 0;
    bit finished = 1'b0;

    always #4 clk = ~clk;

    shift_ctl_sel i_shift_ctl_sel (
        .clk(clk), .rst_n(rst_n), .cmd_i(cmd_i), .ifield_i(ifield_i),
        .rbus_i(rbus_i), .alo_i(alo_i), .amt_o(amt_o), .typ_o(typ_o), .oor_o(oor_o)
    );

    task automatic chk(input string req, input int ea, input int et, input int eo);
        n_chk++;
        if (amt_o !== 5'(ea) || typ_o !== 2'(et) || oor_o !== 1'(eo)) begin
            n_bad++;
            $display("FAIL %s: amt=%0d typ=%0d oor=%0d expected amt=%0d typ=%0d oor=%0d",
                     req, amt_o, typ_o, oor_o, ea, et, eo);
        end
    endtask

    // drive after a falling edge, sample shortly after
    task automatic drive(input logic [2:0] c, input logic [6:0] f, input logic [7:0] rb, input logic [1:0] a);
        @(negedge clk);
        cmd_i = c; ifield_i = f; rbus_i = rb; alo_i = a;
        #1;
    endtask

    task automatic load_byte(input logic [7:0] v);
        drive(3'b111, 7'h55, v, 2'd3);
        chk("R2 load cycle outputs", 0, 0, 0);
    endtask

    task automatic t_reset;
        drive(3'b000, 7'b0000010, 8'hAA, 2'd0);
        chk("R1 reset hold zero", 0, 2, 0);
    endtask

    task automatic t_load_use;
        load_byte(8'd13);
        drive(3'b000, 7'b0000001, 8'd0, 2'd0);
        chk("R4 held amount 13 type LSR", 13, 1, 0);
        load_byte(8'd31);
        drive(3'b000, 7'b0000011, 8'd0, 2'd0);
        chk("R4 held amount 31 type ROR", 31, 3, 0);
    endtask

    task automatic t_hold_keep;
        load_byte(8'd9);
        for (int c = 0; c < 7; c++) begin
            drive(3'(c), 7'(c * 11), 8'(200 + c), 2'(c));
        end
        drive(3'b000, 7'b0000010, 8'hFF, 2'd0);
        chk("R3 hold unchanged by other commands", 9, 2, 0);
    endtask

    task automatic t_oor;
        load_byte(8'd32);
        drive(3'b000, 7'b0000001, 8'd0, 2'd0);
        chk("R5 held 32 out of range", 0, 1, 1);
        load_byte(8'd255);
        drive(3'b000, 7'b0000000, 8'd0, 2'd0);
        chk("R5 held 255 out of range", 0, 0, 1);
        drive(3'b001, 7'b1111111, 8'd0, 2'd0);
        chk("R5 no flag on other command", 31, 3, 0);
    endtask

    task automatic t_field;
        drive(3'b001, 7'b1011010, 8'd0, 2'd0);
        chk("R6 field amount 22 type ASR", 22, 2, 0);
        drive(3'b001, 7'b0000101, 8'd0, 2'd0);
        chk("R6 field amount 1 type LSR", 1, 1, 0);
    endtask

    task automatic t_nop;
        drive(3'b010, 7'b1111111, 8'hFF, 2'd3);
        chk("R7 no-op", 0, 0, 0);
    endtask

    task automatic t_branch;
        drive(3'b011, 7'b0110110, 8'd0, 2'd2);
        chk("R8 branch shift", 2, 0, 0);
    endtask

    task automatic t_imm;
        for (int r = 0; r < 16; r += 5) begin
            drive(3'b100, 7'((r << 3) | 3'b101), 8'd0, 2'd0);
            chk("R9 doubled rotate", 2 * r, (r != 0) ? 3 : 0, 0);
        end
    endtask

    task automatic t_byte;
        for (int a = 0; a < 4; a++) begin
            drive(3'b101, 7'h3C, 8'd0, 2'(a));
            chk("R10 byte lane rotate", 8 * a, (a != 0) ? 3 : 0, 0);
        end
    endtask

    task automatic t_spare;
        load_byte(8'd7);
        drive(3'b110, 7'b1111111, 8'hFF, 2'd1);
        chk("R11 spare command", 0, 0, 0);
    endtask

    initial begin
        #(8 * 200000);
        if (!finished) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog: run did not end, expected completion");
            $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        t_load_use();
        t_hold_keep();
        t_oor();
        t_field();
        t_nop();
        t_branch();
        t_imm();
        t_byte();
        t_spare();
        finished = 1'b1;
        $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
        $finish;
    end

endmodule